// File: doc/BRIEF.md
# Handshaking Parallel Port Controller

This block gives a processor three 8-bit parallel ports, A, B and C, through a four-byte register window on a plain 8-bit bus. The ports form two halves of twelve lines each. The first half is port A with the high nibble of C. The second half is port B with the low nibble of C. One control byte sets the mode and direction of both halves.

Each half runs in one of two modes. In plain mode it acts as latched general-purpose I/O. In strobed mode, some port C lines carry a strobe/acknowledge handshake with an external device, plus an interrupt request. A second kind of control write sets or clears a single port C bit. That same write is how the per-port interrupt enables are switched.

The bus is synchronous. A write or read is a one-cycle pulse on `busWr` or `busRd`, with read data returned combinationally. Handshake inputs are assumed to be synchronous to `clk`. Each pin has a data output and an enable. A line that is not an output presents 0 on its data output.

Top module: `ppi_top`

## Requirements
- R1: Offset 0 reaches port A, offset 1 reaches port B and offset 2 reaches port C or its status. Offset 3 is the write-only control register, and a read of it returns 0x00.
- R2: A control write with bit 7 = 1 defines the mode. Bit 5 puts the A half in strobed mode, bit 4 makes A an input, bit 3 makes C[7:4] inputs, bit 2 puts the B half in strobed mode, bit 1 makes B an input and bit 0 makes C[3:0] inputs. Bit 6 is ignored.
- R3: After reset all lines are inputs. Every mode-definition write clears the A, B and C output latches, all buffer-full and interrupt flags, and with them every interrupt enable.
- R4: In plain mode an output port drives its latch with the enables high. A read of an input port returns the live pins, and a read of an output port returns its latch.
- R5: A control write with bit 7 = 0 loads bit 0 into the port C latch bit selected by bits 3:1. No other latch bit and no part of the mode configuration changes.
- R6: Strobed input uses these port C lines: for A, strobe C4, buffer-full C5 and interrupt C3; for B, strobe C2, buffer-full C1 and interrupt C0. A falling strobe captures the port pins and sets buffer-full. A read of that port returns the captured byte, not the live pins.
- R7: In strobed input, a rising strobe sets the interrupt while buffer-full and the enable are both 1. A read of the port clears both the interrupt and buffer-full.
- R8: Strobed output uses these port C lines: for A, acknowledge C6, active-low buffer-full C7 and interrupt C3; for B, acknowledge C2, active-low buffer-full C1 and interrupt C0. A port write drives the new byte, pulls buffer-full low and clears the interrupt. A falling acknowledge returns buffer-full high. A rising acknowledge then sets the interrupt if the enable is 1.
- R9: Each strobed port's interrupt enable is the port C latch bit at its strobe/acknowledge position: C4 for A input, C6 for A output, C2 for B. With that bit at 0 the interrupt stays low.
- R10: A read of offset 2 returns the live value of handshake outputs and the enable bit at each strobe/acknowledge position. Every other bit reads as in plain mode.
- R11: With the A half in strobed output, C4 and C5 remain general-purpose lines whose direction follows control bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 2 | Register offset |
| busWrData | input | 8 | Write data |
| busWr | input | 1 | One-cycle write pulse |
| busRd | input | 1 | One-cycle read pulse |
| busRdData | output | 8 | Read data (combinational) |
| portAIn | input | 8 | Port A pin levels |
| portAOut | output | 8 | Port A drive values |
| portAOe | output | 8 | Port A output enables |
| portBIn | input | 8 | Port B pin levels |
| portBOut | output | 8 | Port B drive values |
| portBOe | output | 8 | Port B output enables |
| portCIn | input | 8 | Port C pin levels, including strobe/acknowledge |
| portCOut | output | 8 | Port C drive values, including handshake outputs |
| portCOe | output | 8 | Port C output enables |

## Verification
The bench builds the block with the package defaults: 8-bit ports and a 3-bit port C bit selector. These are the only sizes for which the handshake line positions are defined. At this size every port C bit can be reached by the set/reset command. Every combination of plain and strobed mode, in each direction, can be reached with a handful of control bytes. The bench uses this to cover full input and output handshakes on both halves, with the enable both on and off, and status reads taken mid-handshake.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  localparam int PORT_W = 8;
  localparam int SEL_W  = $clog2(PORT_W);
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] OFS_A   = 2'd0;
  localparam logic [ADDR_W-1:0] OFS_B   = 2'd1;
  localparam logic [ADDR_W-1:0] OFS_C   = 2'd2;
  localparam logic [ADDR_W-1:0] OFS_CTL = 2'd3;

  localparam int CTL_DEF_BIT = PORT_W - 1;

  // Port C positions used by the handshakes
  localparam int PC_INTR_A = 3;
  localparam int PC_STB_A  = 4;
  localparam int PC_IBF_A  = 5;
  localparam int PC_ACK_A  = 6;
  localparam int PC_OBF_A  = 7;
  localparam int PC_INTR_B = 0;
  localparam int PC_BUF_B  = 1;
  localparam int PC_LINE_B = 2;

  typedef struct packed {
    logic aStrobed;
    logic aIsIn;
    logic cHiIsIn;
    logic bStrobed;
    logic bIsIn;
    logic cLoIsIn;
  } cfg_t;

  typedef struct packed {
    logic             wrA;
    logic             wrB;
    logic             wrC;
    logic             wrMode;
    logic             wrBit;
    logic [SEL_W-1:0] bitSel;
    logic             bitVal;
    logic             capA;
    logic             capB;
  } strb_t;

  typedef struct packed {
    logic bufFull;
    logic intr;
  } hs_t;
endpackage

// File: rtl/ppi_hshk.sv
module ppi_hshk
  import ppi_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic clear,
  input  logic strobed,
  input  logic isIn,
  input  logic inte,
  input  logic linePin,
  input  logic cpuRd,
  input  logic cpuWr,
  output hs_t  st,
  output logic capture
);
  logic lineQ, fallE, riseE, fullQ, intrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lineQ <= 1'b1;
    else       lineQ <= linePin;
  end

  assign fallE   = lineQ & ~linePin;
  assign riseE   = ~lineQ & linePin;
  assign capture = strobed & isIn & fallE & ~clear;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fullQ <= 1'b0;
      intrQ <= 1'b0;
    end else if (clear) begin
      fullQ <= 1'b0;
      intrQ <= 1'b0;
    end else if (strobed) begin
      if (isIn) begin
        if (cpuRd) begin
          fullQ <= 1'b0;
          intrQ <= 1'b0;
        end else begin
          if (fallE) fullQ <= 1'b1;
          if (riseE && fullQ && inte) intrQ <= 1'b1;
        end
      end else begin
        if (cpuWr) begin
          fullQ <= 1'b1;
          intrQ <= 1'b0;
        end else begin
          if (fallE) fullQ <= 1'b0;
          if (riseE && !fullQ && inte) intrQ <= 1'b1;
        end
      end
    end
  end

  assign st = '{bufFull: fullQ, intr: intrQ};

  AST_CLEAR_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> (!fullQ && !intrQ)); // R3
  AST_CAPTURE_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (capture && !cpuRd) |=> fullQ); // R6
  AST_IN_INTR_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (strobed && isIn && intrQ) |-> fullQ); // R7
  AST_OUT_INTR_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (strobed && !isIn && intrQ) |-> !fullQ); // R8
endmodule

// File: rtl/ppi_ctrl.sv
module ppi_ctrl
  import ppi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [PORT_W-1:0] busWrData,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [PORT_W-1:0] portCIn,
  input  logic [PORT_W-1:0] cLatch,
  output cfg_t              cfg,
  output strb_t             strb,
  output hs_t               hsA,
  output hs_t               hsB
);
  localparam int NPORT = 2;

  logic ctlWr;
  logic [NPORT-1:0] strobedV, isInV, inteV, lineV, rdV, wrV, capV;
  hs_t hsV [NPORT];

  assign ctlWr = busWr && (busAddr == OFS_CTL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg <= '{aStrobed: 1'b0, aIsIn: 1'b1, cHiIsIn: 1'b1,
               bStrobed: 1'b0, bIsIn: 1'b1, cLoIsIn: 1'b1};
    end else if (ctlWr && busWrData[CTL_DEF_BIT]) begin
      cfg <= '{aStrobed: busWrData[5], aIsIn: busWrData[4], cHiIsIn: busWrData[3],
               bStrobed: busWrData[2], bIsIn: busWrData[1], cLoIsIn: busWrData[0]};
    end
  end

  // Per-port view of configuration and port C handshake lines
  assign strobedV = {cfg.bStrobed, cfg.aStrobed};
  assign isInV    = {cfg.bIsIn, cfg.aIsIn};
  assign lineV    = {portCIn[PC_LINE_B], cfg.aIsIn ? portCIn[PC_STB_A] : portCIn[PC_ACK_A]};
  assign inteV    = {cLatch[PC_LINE_B],  cfg.aIsIn ? cLatch[PC_STB_A]  : cLatch[PC_ACK_A]};
  assign rdV      = {busRd && (busAddr == OFS_B), busRd && (busAddr == OFS_A)};
  assign wrV      = {busWr && (busAddr == OFS_B), busWr && (busAddr == OFS_A)};

  for (genvar g = 0; g < NPORT; g++) begin : g_hs
    ppi_hshk u_hs (
      .clk     (clk),
      .rstN    (rstN),
      .clear   (strb.wrMode),
      .strobed (strobedV[g]),
      .isIn    (isInV[g]),
      .inte    (inteV[g]),
      .linePin (lineV[g]),
      .cpuRd   (rdV[g]),
      .cpuWr   (wrV[g]),
      .st      (hsV[g]),
      .capture (capV[g])
    );
  end

  assign hsA = hsV[0];
  assign hsB = hsV[1];

  always_comb begin
    strb        = '0;
    strb.wrA    = wrV[0];
    strb.wrB    = wrV[1];
    strb.wrC    = busWr && (busAddr == OFS_C);
    strb.wrMode = ctlWr && busWrData[CTL_DEF_BIT];
    strb.wrBit  = ctlWr && !busWrData[CTL_DEF_BIT];
    strb.bitSel = busWrData[SEL_W:1];
    strb.bitVal = busWrData[0];
    strb.capA   = capV[0];
    strb.capB   = capV[1];
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ctlWr && !busWrData[CTL_DEF_BIT]) |=> $stable(cfg)); // R5
endmodule

// File: rtl/ppi_dp.sv
module ppi_dp
  import ppi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strb_t             strb,
  input  cfg_t              cfg,
  input  hs_t               hsA,
  input  hs_t               hsB,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [PORT_W-1:0] busWrData,
  input  logic [PORT_W-1:0] portAIn,
  input  logic [PORT_W-1:0] portBIn,
  input  logic [PORT_W-1:0] portCIn,
  output logic [PORT_W-1:0] portAOut,
  output logic [PORT_W-1:0] portAOe,
  output logic [PORT_W-1:0] portBOut,
  output logic [PORT_W-1:0] portBOe,
  output logic [PORT_W-1:0] portCOut,
  output logic [PORT_W-1:0] portCOe,
  output logic [PORT_W-1:0] busRdData,
  output logic [PORT_W-1:0] cLatch
);
  localparam int HALF = PORT_W / 2;

  logic [PORT_W-1:0] aLat, bLat, cLat, aCap, bCap;
  logic [PORT_W-1:0] cVal, cOeV, inteMask, cRd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aLat <= '0; bLat <= '0; cLat <= '0; aCap <= '0; bCap <= '0;
    end else begin
      if (strb.wrMode) begin
        aLat <= '0; bLat <= '0; cLat <= '0; aCap <= '0; bCap <= '0;
      end else begin
        if (strb.wrA)   aLat <= busWrData;
        if (strb.wrB)   bLat <= busWrData;
        if (strb.wrC)   cLat <= busWrData;
        if (strb.wrBit) cLat[strb.bitSel] <= strb.bitVal;
        if (strb.capA)  aCap <= portAIn;
        if (strb.capB)  bCap <= portBIn;
      end
    end
  end

  // Port C line roles
  always_comb begin
    cOeV     = {{HALF{~cfg.cHiIsIn}}, {HALF{~cfg.cLoIsIn}}};
    cVal     = cLat;
    inteMask = '0;
    if (cfg.aStrobed) begin
      cOeV[PC_INTR_A] = 1'b1;
      cVal[PC_INTR_A] = hsA.intr;
      if (cfg.aIsIn) begin
        cOeV[PC_STB_A]     = 1'b0;
        cOeV[PC_IBF_A]     = 1'b1;
        cVal[PC_IBF_A]     = hsA.bufFull;
        inteMask[PC_STB_A] = 1'b1;
      end else begin
        cOeV[PC_ACK_A]     = 1'b0;
        cOeV[PC_OBF_A]     = 1'b1;
        cVal[PC_OBF_A]     = ~hsA.bufFull;
        inteMask[PC_ACK_A] = 1'b1;
      end
    end
    if (cfg.bStrobed) begin
      cOeV[PC_LINE_B]     = 1'b0;
      cOeV[PC_BUF_B]      = 1'b1;
      cVal[PC_BUF_B]      = cfg.bIsIn ? hsB.bufFull : ~hsB.bufFull;
      cOeV[PC_INTR_B]     = 1'b1;
      cVal[PC_INTR_B]     = hsB.intr;
      inteMask[PC_LINE_B] = 1'b1;
    end
  end

  always_comb begin
    for (int i = 0; i < PORT_W; i++) begin
      cRd[i] = inteMask[i] ? cLat[i] : (cOeV[i] ? cVal[i] : portCIn[i]);
    end
  end

  assign portAOe  = {PORT_W{~cfg.aIsIn}};
  assign portBOe  = {PORT_W{~cfg.bIsIn}};
  assign portAOut = aLat & portAOe;
  assign portBOut = bLat & portBOe;
  assign portCOe  = cOeV;
  assign portCOut = cVal & cOeV;
  assign cLatch   = cLat;

  always_comb begin
    unique case (busAddr)
      OFS_A:   busRdData = cfg.aIsIn ? (cfg.aStrobed ? aCap : portAIn) : aLat;
      OFS_B:   busRdData = cfg.bIsIn ? (cfg.bStrobed ? bCap : portBIn) : bLat;
      OFS_C:   busRdData = cRd;
      default: busRdData = '0;
    endcase
  end

  AST_MODE_CLEARS_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrMode |=> (aLat == '0 && bLat == '0 && cLat == '0)); // R3
  AST_BIT_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrBit |=> (((cLat ^ $past(cLat)) & ~(PORT_W'(1) << $past(strb.bitSel))) == '0)); // R5
endmodule

// File: rtl/ppi_top.sv
module ppi_top
  import ppi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [PORT_W-1:0] busWrData,
  input  logic              busWr,
  input  logic              busRd,
  output logic [PORT_W-1:0] busRdData,
  input  logic [PORT_W-1:0] portAIn,
  output logic [PORT_W-1:0] portAOut,
  output logic [PORT_W-1:0] portAOe,
  input  logic [PORT_W-1:0] portBIn,
  output logic [PORT_W-1:0] portBOut,
  output logic [PORT_W-1:0] portBOe,
  input  logic [PORT_W-1:0] portCIn,
  output logic [PORT_W-1:0] portCOut,
  output logic [PORT_W-1:0] portCOe
);
  cfg_t              cfg;
  strb_t             strb;
  hs_t               hsA, hsB;
  logic [PORT_W-1:0] cLatch;

  ppi_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWr(busWr), .busRd(busRd), .portCIn(portCIn), .cLatch(cLatch),
    .cfg(cfg), .strb(strb), .hsA(hsA), .hsB(hsB)
  );

  ppi_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfg(cfg), .hsA(hsA), .hsB(hsB),
    .busAddr(busAddr), .busWrData(busWrData),
    .portAIn(portAIn), .portBIn(portBIn), .portCIn(portCIn),
    .portAOut(portAOut), .portAOe(portAOe), .portBOut(portBOut), .portBOe(portBOe),
    .portCOut(portCOut), .portCOe(portCOe), .busRdData(busRdData), .cLatch(cLatch)
  );
endmodule

// File: tb/ppi_top_tb.sv
module ppi_top_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic       busWr = 1'b0, busRd = 1'b0;
  logic [7:0] busRdData;
  logic [7:0] aPins = '0, bPins = '0, cPins = '0;
  logic [7:0] portAOut, portAOe, portBOut, portBOe, portCOut, portCOe;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    string      tag;
    int         sel;
    logic [7:0] exp;
  } item_t;
  item_t sbq[$];
  event sampleEv;

  localparam int RD = 0, AO = 1, AE = 2, BO = 3, BE = 4, CO = 5, CE = 6;

  always #10 clk = ~clk;

  ppi_top u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWr(busWr), .busRd(busRd), .busRdData(busRdData),
    .portAIn(aPins), .portAOut(portAOut), .portAOe(portAOe),
    .portBIn(bPins), .portBOut(portBOut), .portBOe(portBOe),
    .portCIn(cPins), .portCOut(portCOut), .portCOe(portCOe)
  );

  function automatic logic [7:0] obs(int sel);
    case (sel)
      RD: return busRdData;
      AO: return portAOut;
      AE: return portAOe;
      BO: return portBOut;
      BE: return portBOe;
      CO: return portCOut;
      CE: return portCOe;
      default: return 8'h00;
    endcase
  endfunction

  // Monitor: pops expected items and compares them with the design
  initial begin
    forever begin
      @(sampleEv);
      while (sbq.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = sbq.pop_front();
        act = obs(it.sel);
        vectors++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s: got %02h expected %02h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic want(int sel, logic [7:0] e, string tag);
    sbq.push_back('{tag: tag, sel: sel, exp: e});
    ->sampleEv;
  endtask

  task automatic settle();
    @(negedge clk); #5;
  endtask

  task automatic wrBus(logic [1:0] a, logic [7:0] d);
    @(negedge clk); busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic rdBus(logic [1:0] a, logic [7:0] e, string tag);
    @(negedge clk); busAddr = a; busRd = 1'b1;
    #5 want(RD, e, tag);
    @(negedge clk); busRd = 1'b0;
  endtask

  task automatic setC(logic [7:0] v);
    @(negedge clk); cPins = v;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // Reset state
    settle();
    want(AE, 8'h00, "R3 reset A inputs");
    want(BE, 8'h00, "R3 reset B inputs");
    want(CE, 8'h00, "R3 reset C inputs");
    rdBus(2'd3, 8'h00, "R1 control reads zero");

    // Plain mode, all outputs
    wrBus(2'd3, 8'h80);
    wrBus(2'd0, 8'h5A);
    settle(); want(AO, 8'h5A, "R4 A drive"); want(AE, 8'hFF, "R4 A enable");
    wrBus(2'd1, 8'hC3);
    settle(); want(BO, 8'hC3, "R4 B drive");
    wrBus(2'd2, 8'h96);
    settle(); want(CO, 8'h96, "R4 C drive"); want(CE, 8'hFF, "R4 C enable");
    rdBus(2'd0, 8'h5A, "R4 A readback latch");
    rdBus(2'd2, 8'h96, "R1 C readback latch");

    // Single-bit set/reset of port C
    wrBus(2'd3, 8'h0B);
    settle(); want(CO, 8'hB6, "R5 set bit5");
    wrBus(2'd3, 8'h0E);
    settle(); want(CO, 8'h36, "R5 clear bit7");
    want(AE, 8'hFF, "R5 mode unchanged");

    // Plain mode, all inputs
    wrBus(2'd3, 8'h9B);
    settle(); want(AE, 8'h00, "R2 A input"); want(CO, 8'h00, "R3 latch cleared");
    @(negedge clk); aPins = 8'h3C; bPins = 8'hE1; cPins = 8'h7F;
    rdBus(2'd0, 8'h3C, "R4 A pins");
    rdBus(2'd1, 8'hE1, "R4 B pins");
    rdBus(2'd2, 8'h7F, "R4 C pins");

    // Mixed direction on port C
    wrBus(2'd3, 8'h8A);
    wrBus(2'd2, 8'hAB);
    setC(8'h50);
    settle(); want(CE, 8'h0F, "R2 C split"); want(CO, 8'h0B, "R2 C low drive");
    want(BE, 8'h00, "R2 B input");
    rdBus(2'd2, 8'h5B, "R4 C mixed read");

    // Bit 6 of a mode word is ignored
    wrBus(2'd3, 8'hC0);
    settle(); want(CE, 8'hFF, "R2 bit6 ignored");

    // Strobed input on port A
    setC(8'h10);
    wrBus(2'd3, 8'hBB);
    settle(); want(CE, 8'h28, "R6 A input roles"); want(CO, 8'h00, "R6 idle");
    wrBus(2'd3, 8'h09);
    settle(); want(CE, 8'h28, "R5 mode held after set");
    @(negedge clk); aPins = 8'hA5;
    setC(8'h00);
    settle(); want(CO, 8'h20, "R6 buffer full");
    @(negedge clk); aPins = 8'h11;
    setC(8'h10);
    settle(); want(CO, 8'h28, "R7 interrupt");
    rdBus(2'd2, 8'h38, "R10 input status");
    rdBus(2'd0, 8'hA5, "R6 captured byte");
    settle(); want(CO, 8'h00, "R7 read clears");
    wrBus(2'd3, 8'h08);
    setC(8'h00);
    setC(8'h10);
    settle(); want(CO, 8'h20, "R9 no interrupt when disabled");
    rdBus(2'd0, 8'h11, "R6 second capture");

    // Strobed output on both ports
    setC(8'h44);
    wrBus(2'd3, 8'hA4);
    settle(); want(CE, 8'hBB, "R8 output roles"); want(CO, 8'h82, "R8 idle");
    wrBus(2'd3, 8'h0B);
    settle(); want(CO, 8'hA2, "R11 C5 general");
    wrBus(2'd3, 8'h0A);
    wrBus(2'd3, 8'h0D);
    settle(); want(CO, 8'h82, "R9 enable not driven");
    wrBus(2'd0, 8'h77);
    settle(); want(AO, 8'h77, "R8 A drive"); want(CO, 8'h02, "R8 buffer full low");
    setC(8'h04);
    settle(); want(CO, 8'h82, "R8 ack releases");
    setC(8'h44);
    settle(); want(CO, 8'h8A, "R8 interrupt");
    rdBus(2'd2, 8'hCA, "R10 output status");
    wrBus(2'd0, 8'h12);
    settle(); want(CO, 8'h02, "R8 write clears interrupt");
    wrBus(2'd1, 8'h33);
    settle(); want(BO, 8'h33, "R8 B drive"); want(CO, 8'h00, "R8 B buffer full");
    setC(8'h40);
    settle(); want(CO, 8'h02, "R8 B ack releases");
    setC(8'h44);
    settle(); want(CO, 8'h02, "R9 B disabled");
    wrBus(2'd3, 8'h05);
    wrBus(2'd1, 8'h44);
    setC(8'h40);
    setC(8'h44);
    settle(); want(CO, 8'h03, "R8 B interrupt");
    wrBus(2'd3, 8'hA4);
    settle(); want(CO, 8'h82, "R3 flags cleared"); want(AO, 8'h00, "R3 A latch cleared");
    wrBus(2'd0, 8'h01);
    setC(8'h04);
    setC(8'h44);
    settle(); want(CO, 8'h82, "R3 enable cleared");

    // Strobed input on port B
    wrBus(2'd3, 8'h86);
    settle(); want(CE, 8'hFB, "R6 B input roles");
    wrBus(2'd3, 8'h05);
    @(negedge clk); bPins = 8'h9C;
    setC(8'h40);
    settle(); want(CO, 8'h02, "R6 B buffer full");
    setC(8'h44);
    settle(); want(CO, 8'h03, "R7 B interrupt");
    rdBus(2'd1, 8'h9C, "R6 B captured");
    settle(); want(CO, 8'h00, "R7 B read clears");

    #1;
    if (sbq.size() != 0) begin
      fails++;
      $display("FAIL scoreboard: got %0d pending expected 0", sbq.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule